// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM with a pipelined read path and a built-in four-beat burst sequencer. The array is parameterized; by default it holds 256 words of 36 bits, organized as four 9-bit byte lanes. A host starts an access by pulling one of two address strobes low. One strobe is meant for a processor and the other for a cache controller. Every later beat of the burst is addressed inside the block by a 2-bit counter on the two low address bits, which steps on each clock where the advance input is low. A static order input picks either wrap-around increment or XOR-interleaved sequencing.

Three chip enables decide at each strobe whether the device takes part in the accesses that follow. Several devices can share one data bus this way. Once a deselecting strobe has passed through the pipeline, the data output is quiet. Writes can cover the whole word through a global write strobe, or any subset of lanes through a per-lane enable group qualified by a master enable. Read data leaves through an output register and is further gated by an asynchronous output enable.

Top module: `burst_sram`

## Requirements
- R1: A new address and selection state are taken only when the controller strobe `ctl_stb_n_i` is low, or when the processor strobe `cpu_stb_n_i` is low while `ce_n_i` is low. A processor strobe seen with `ce_n_i` high is ignored, and the current burst address is kept.
- R2: With `order_il_i`=0, the low two address bits of burst beat n equal the start value plus n, modulo 4. The upper bits stay at the captured value.
- R3: With `order_il_i`=1, the low two address bits of burst beat n equal the start value XOR n.
- R4: On a cycle with no strobe taken and `adv_n_i` high, the counter holds and the access repeats the current burst address.
- R5: When `all_we_n_i` is low, all four lanes of the current address are written, regardless of `byte_we_master_n_i` and `byte_we_n_i`.
- R6: When `all_we_n_i` is high and `byte_we_master_n_i` is low, each low bit i of `byte_we_n_i` writes only lane i, which is data bits [9i+8:9i]. When `byte_we_master_n_i` is high, no lane is written and the cycle is a read.
- R7: A read access whose inputs are sampled at rising edge k presents its word on `rdata_o` with `rvalid_o`=1 after edge k+2. Write accesses produce no valid output.
- R8: While `out_en_n_i` is high, `rvalid_o` is 0 and `rdata_o` is 0 in the same cycle, with no clock edge needed.
- R9: A strobe taken while any enable is inactive (`ce_n_i` high, `ce_hi_i` low or `ce2_n_i` high) deselects the device. From edge k+2 on, `rvalid_o` is 0 and no write occurs, until a selecting strobe.
- R10: A synchronous active-high `rst` deselects the device and clears the read pipeline, so `rvalid_o` is 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, taken on a strobe |
| wdata_i | input | LANES*LANE_W | Write data |
| ce_n_i | input | 1 | Primary chip enable, active low; also qualifies the processor strobe |
| ce_hi_i | input | 1 | Depth-expansion enable, active high |
| ce2_n_i | input | 1 | Depth-expansion enable, active low |
| cpu_stb_n_i | input | 1 | Processor address strobe, active low |
| ctl_stb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| byte_we_n_i | input | LANES | Per-lane write enables, active low |
| byte_we_master_n_i | input | 1 | Master qualifier for the lane enables, active low |
| all_we_n_i | input | 1 | Global write of all lanes, active low |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| order_il_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle, the bound checker confirms three pipeline timings. A deselecting strobe always leaves the output quiet three samples later. A selected read strobe always yields valid data at that point, unless the output enable is off. A selected global write never yields valid data. The checker also confirms that the output is quiet once reset is released. The burst address sequences in both orders, the lane merging of partial writes against older data, and the repeat-on-hold behaviour can only be shown by the bench's scenarios. So can the ignored processor strobe and the instant effect of the output enable, because each of these shows up only in the data values read back.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits for a burst beat, given the start bits and count.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORD_INTERLEAVE) r = start ^ cnt;
    else                       r = start + cnt;
    return r;
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_stb_n_i,
  input  logic              ctl_stb_n_i,
  input  logic              adv_n_i,
  input  logic              ce_n_i,
  input  logic              ce_hi_i,
  input  logic              ce2_n_i,
  input  logic              order_il_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              cur_sel_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              sel_q, sel_d;
  logic              take;
  burst_order_e      ord;

  assign ord  = burst_order_e'(order_il_i);
  assign take = !ctl_stb_n_i || (!cpu_stb_n_i && !ce_n_i);

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (take) begin
      base_d = addr_i;
      cnt_d  = 2'd0;
      sel_d  = !ce_n_i && ce_hi_i && !ce2_n_i;
    end else if (!adv_n_i && sel_q) begin
      cnt_d  = cnt_q + 2'd1;
    end
  end

  // Address of the access made on this edge.
  always_comb begin
    cur_addr_o      = base_d;
    cur_addr_o[1:0] = burst_low(base_d[1:0], cnt_d, ord);
    cur_sel_o       = sel_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      cnt_q  <= 2'd0;
      base_q <= '0;
    end else begin
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/byte_we_decode.sv
module byte_we_decode #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] byte_we_n_i,
  input  logic             master_n_i,
  input  logic             all_we_n_i,
  output logic [LANES-1:0] lane_we_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we_o[l] = !all_we_n_i || (!master_n_i && !byte_we_n_i[l]);
  end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (re_i)    rd_q        <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ce_n_i,
  input  logic              ce_hi_i,
  input  logic              ce2_n_i,
  input  logic              cpu_stb_n_i,
  input  logic              ctl_stb_n_i,
  input  logic              adv_n_i,
  input  logic [LANES-1:0]  byte_we_n_i,
  input  logic              byte_we_master_n_i,
  input  logic              all_we_n_i,
  input  logic              out_en_n_i,
  input  logic              order_il_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] cur_addr;
  logic              cur_sel;
  logic [LANES-1:0]  lane_we;

  // Access stage: the registered form of this cycle's inputs.
  logic              acc_v_q;
  logic              acc_wr_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic [LANES-1:0]  acc_lanes_q;
  logic [DATA_W-1:0] acc_data_q;

  logic [DATA_W-1:0] bank_rdata;
  logic              rd_v1_q;
  logic [DATA_W-1:0] dout_q;
  logic              dv_q;

  burst_addr_gen #(.ADDR_W(ADDR_W)) addr_gen_i (
    .clk         (clk),
    .rst         (rst),
    .addr_i      (addr_i),
    .cpu_stb_n_i (cpu_stb_n_i),
    .ctl_stb_n_i (ctl_stb_n_i),
    .adv_n_i     (adv_n_i),
    .ce_n_i      (ce_n_i),
    .ce_hi_i     (ce_hi_i),
    .ce2_n_i     (ce2_n_i),
    .order_il_i  (order_il_i),
    .cur_addr_o  (cur_addr),
    .cur_sel_o   (cur_sel)
  );

  byte_we_decode #(.LANES(LANES)) we_dec_i (
    .byte_we_n_i (byte_we_n_i),
    .master_n_i  (byte_we_master_n_i),
    .all_we_n_i  (all_we_n_i),
    .lane_we_o   (lane_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_v_q  <= 1'b0;
      acc_wr_q <= 1'b0;
    end else begin
      acc_v_q  <= cur_sel;
      acc_wr_q <= |lane_we;
    end
    acc_addr_q  <= cur_addr;
    acc_lanes_q <= lane_we;
    acc_data_q  <= wdata_i;
  end

  sram_lane_bank #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) bank_i (
    .clk     (clk),
    .addr_i  (acc_addr_q),
    .we_i    (acc_lanes_q & {LANES{acc_v_q}}),
    .re_i    (acc_v_q && !acc_wr_q),
    .wdata_i (acc_data_q),
    .rdata_o (bank_rdata)
  );

  // Output register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1_q <= 1'b0;
      dv_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      rd_v1_q <= acc_v_q && !acc_wr_q;
      dv_q    <= rd_v1_q;
      dout_q  <= bank_rdata;
    end
  end

  assign rvalid_o = dv_q && !out_en_n_i;
  assign rdata_o  = rvalid_o ? dout_q : '0;

endmodule

// File: rtl/burst_sram_checks.sv
module burst_sram_checks #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n_i,
  input logic              ce_hi_i,
  input logic              ce2_n_i,
  input logic              cpu_stb_n_i,
  input logic              ctl_stb_n_i,
  input logic [LANES-1:0]  byte_we_n_i,
  input logic              byte_we_master_n_i,
  input logic              all_we_n_i,
  input logic              out_en_n_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);

  logic strobe_taken, all_enabled, any_write;

  assign strobe_taken = !ctl_stb_n_i || (!cpu_stb_n_i && !ce_n_i);
  assign all_enabled  = !ce_n_i && ce_hi_i && !ce2_n_i;
  assign any_write    = !all_we_n_i || (!byte_we_master_n_i && !(&byte_we_n_i));

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rvalid_o);

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe_taken && !all_enabled) |-> ##3 !rvalid_o);

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe_taken && all_enabled && !any_write) |-> ##3 (rvalid_o || out_en_n_i));

  assert_write_no_data_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe_taken && all_enabled && !all_we_n_i) |-> ##3 !rvalid_o);

  assert_quiet_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !rvalid_o |-> (rdata_o == '0));

endmodule

bind burst_sram burst_sram_checks #(
  .LANES  (LANES),
  .DATA_W (LANES * LANE_W)
) checks_i (
  .clk                (clk),
  .rst                (rst),
  .ce_n_i             (ce_n_i),
  .ce_hi_i            (ce_hi_i),
  .ce2_n_i            (ce2_n_i),
  .cpu_stb_n_i        (cpu_stb_n_i),
  .ctl_stb_n_i        (ctl_stb_n_i),
  .byte_we_n_i        (byte_we_n_i),
  .byte_we_master_n_i (byte_we_master_n_i),
  .all_we_n_i         (all_we_n_i),
  .out_en_n_i         (out_en_n_i),
  .rdata_o            (rdata_o),
  .rvalid_o           (rvalid_o)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;
  localparam int NVEC   = 9;

  typedef struct packed {
    logic        wr;
    logic        use_ctl;
    logic        il;
    logic [2:0]  len;
    logic        gw_n;
    logic        mst_n;
    logic [3:0]  lanes_n;
    logic [7:0]  addr;
    logic [15:0] seed;
  } vec_t;

  // Burst table: each entry is one burst from a strobe, then advancing beats.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 4'hF, 8'h10, 16'h1000}, // R5 R2 full writes
    '{1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1, 4'hF, 8'h12, 16'h0000}, // R2 R7 linear read
    '{1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 4'hF, 8'h11, 16'h0000}, // R3 interleaved read
    '{1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 4'hA, 8'h13, 16'h2000}, // R6 lanes 0,2
    '{1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 1'b1, 4'hF, 8'h12, 16'h0000}, // R3 R6 readback
    '{1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 4'hF, 8'h23, 16'h3000}, // R5 global wins
    '{1'b1, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 4'h0, 8'h23, 16'h7777}, // R6 no master
    '{1'b0, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 4'hF, 8'h23, 16'h0000}, // R2 wrap read
    '{1'b0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b1, 4'hF, 8'h10, 16'h0000}  // R3 R7 read
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic              ce_n_i = 1'b0, ce_hi_i = 1'b1, ce2_n_i = 1'b0;
  logic              cpu_stb_n_i = 1'b1, ctl_stb_n_i = 1'b1, adv_n_i = 1'b1;
  logic [LANES-1:0]  byte_we_n_i = '1;
  logic              byte_we_master_n_i = 1'b1, all_we_n_i = 1'b1;
  logic              out_en_n_i = 1'b0, order_il_i = 1'b0;
  logic [DATA_W-1:0] rdata_o;
  logic              rvalid_o;

  int n_vec  = 0;
  int n_miss = 0;

  always #10 clk = ~clk;

  burst_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk (clk), .rst (rst), .addr_i (addr_i), .wdata_i (wdata_i),
    .ce_n_i (ce_n_i), .ce_hi_i (ce_hi_i), .ce2_n_i (ce2_n_i),
    .cpu_stb_n_i (cpu_stb_n_i), .ctl_stb_n_i (ctl_stb_n_i), .adv_n_i (adv_n_i),
    .byte_we_n_i (byte_we_n_i), .byte_we_master_n_i (byte_we_master_n_i),
    .all_we_n_i (all_we_n_i), .out_en_n_i (out_en_n_i), .order_il_i (order_il_i),
    .rdata_o (rdata_o), .rvalid_o (rvalid_o)
  );

  // Bench model state, derived from the requirements.
  logic [DATA_W-1:0] m_mem [1 << ADDR_W];
  logic              m_sel  = 1'b0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_cnt  = '0;
  logic              h_v [3];
  logic [DATA_W-1:0] h_d [3];
  string             h_t [3];

  task automatic check(input string tag, input logic av, input logic [DATA_W-1:0] ad,
                       input logic ev, input logic [DATA_W-1:0] ed);
    n_vec++;
    if (av !== ev || ad !== ed) begin
      n_miss++;
      $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
               tag, av, ad, ev, ed);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      h_v[i] = 1'b0; h_d[i] = '0; h_t[i] = "R10 after reset";
    end
  endtask

  // Apply the currently driven inputs for one clock and check the output.
  task automatic step(input string tag);
    logic              take, ev;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] mask, ed;
    take = !ctl_stb_n_i || (!cpu_stb_n_i && !ce_n_i);
    if (take) begin
      m_sel  = !ce_n_i && ce_hi_i && !ce2_n_i;
      m_base = addr_i;
      m_cnt  = 2'd0;
    end else if (!adv_n_i && m_sel) begin
      m_cnt = m_cnt + 2'd1;
    end
    a      = m_base;
    a[1:0] = order_il_i ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    mask   = '0;
    for (int l = 0; l < LANES; l++)
      if (!all_we_n_i || (!byte_we_master_n_i && !byte_we_n_i[l]))
        mask[l*LANE_W +: LANE_W] = '1;
    ev = 1'b0; ed = '0;
    if (m_sel && mask != '0)
      m_mem[a] = (m_mem[a] & ~mask) | (wdata_i & mask);
    else if (m_sel) begin
      ev = 1'b1; ed = m_mem[a];
    end
    h_v[2] = h_v[1]; h_d[2] = h_d[1]; h_t[2] = h_t[1];
    h_v[1] = h_v[0]; h_d[1] = h_d[0]; h_t[1] = h_t[0];
    h_v[0] = ev;     h_d[0] = ed;     h_t[0] = tag;
    @(posedge clk);
    @(negedge clk);
    check(h_t[2], rvalid_o, rdata_o, h_v[2], h_d[2]);
  endtask

  task automatic idle_inputs();
    cpu_stb_n_i = 1'b1; ctl_stb_n_i = 1'b1; adv_n_i = 1'b1;
    ce_n_i = 1'b0; ce_hi_i = 1'b1; ce2_n_i = 1'b0;
    all_we_n_i = 1'b1; byte_we_master_n_i = 1'b1; byte_we_n_i = '1;
    wdata_i = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sel = 1'b0; m_cnt = '0;
    clear_hist();
    check("R10 reset state", rvalid_o, rdata_o, 1'b0, '0);
  endtask

  task automatic read_strobe(input logic [ADDR_W-1:0] a, input string tag);
    idle_inputs();
    ctl_stb_n_i = 1'b0; addr_i = a;
    step(tag);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog: run did not complete, expected end of test");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    clear_hist();
    @(negedge clk);
    do_reset();

    // Table walk.
    for (int v = 0; v < NVEC; v++) begin
      string tg;
      tg = $sformatf("R7 table vector %0d (R2 R3 R5 R6)", v);
      order_il_i = VECS[v].il;
      for (int b = 0; b < int'(VECS[v].len); b++) begin
        idle_inputs();
        if (b == 0) begin
          addr_i = VECS[v].addr;
          if (VECS[v].use_ctl) ctl_stb_n_i = 1'b0;
          else                 cpu_stb_n_i = 1'b0;
        end else begin
          adv_n_i = 1'b0;
        end
        if (VECS[v].wr) begin
          all_we_n_i         = VECS[v].gw_n;
          byte_we_master_n_i = VECS[v].mst_n;
          byte_we_n_i        = VECS[v].lanes_n;
          wdata_i            = {4'(b), VECS[v].seed, 16'(VECS[v].seed + 16'(b))};
        end
        step(tg);
      end
    end
    order_il_i = 1'b0;

    // R4: hold without advance repeats the address.
    read_strobe(8'h11, "R4 hold start");
    step("R4 hold repeat 1");
    step("R4 hold repeat 2");

    // R1: processor strobe with primary enable high is ignored.
    cpu_stb_n_i = 1'b0; ce_n_i = 1'b1; addr_i = 8'h20;
    step("R1 ignored processor strobe");
    idle_inputs();
    step("R1 still on old address");
    // R1: processor strobe honoured when primary enable low.
    cpu_stb_n_i = 1'b0; addr_i = 8'h20;
    step("R1 processor strobe taken");
    idle_inputs();
    step("R1 drain 1");
    step("R1 drain 2");

    // R8: output enable acts without a clock edge.
    out_en_n_i = 1'b1;
    #1 check("R8 output enable off", rvalid_o, rdata_o, 1'b0, '0);
    out_en_n_i = 1'b0;
    #1 check("R8 output enable on", rvalid_o, rdata_o, h_v[2], h_d[2]);

    // R9: deselect by the active-high enable, then by the second active-low one.
    ctl_stb_n_i = 1'b0; ce_hi_i = 1'b0; addr_i = 8'h10;
    step("R9 deselect strobe");
    idle_inputs();
    all_we_n_i = 1'b0; wdata_i = 36'hF_FFFF_FFFF;
    step("R9 write while deselected");
    idle_inputs();
    step("R9 quiet 1");
    step("R9 quiet 2");
    read_strobe(8'h10, "R9 reselect read");
    ctl_stb_n_i = 1'b0; ce2_n_i = 1'b1; addr_i = 8'h12;
    step("R9 deselect second enable");
    idle_inputs();
    step("R9 quiet 3");
    step("R9 quiet 4");

    // R10: reset in the middle of a read stream.
    read_strobe(8'h13, "R10 before reset");
    do_reset();
    step("R10 deselected after reset");
    step("R10 deselected after reset 2");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule